// File: doc/BRIEF.md
# Diagnostic LED Multiplexer

This block drives an 8-bit diagnostic LED bank from one of several on-chip status sources. A 4-bit view select picks the source. The available views are link training state, a software-owned LED pattern, the DIP switch bank, the boot-image selection switches, and one status view for each of three I/O module ports. Unused select codes blank the bank. The output is registered and active high. Any polarity inversion needed by the board is done by a later stage.

Each port view combines two kinds of information. The upper nibble carries that port's live interrupt status bits. The lower nibble is a one-hot record of the address space the port is accessing now, or accessed most recently. The record loads when an access strobe rises and holds after the strobe falls. The LED bank therefore keeps showing the last access long after a short bus cycle has finished.

Top module: `diag_led_mux`

## Requirements
- R1: While reset is asserted, `led_o` is 8'h00. Reset also clears every port's space record, so a port view shown right after reset has a lower nibble of 4'b0000.
- R2: `led_o` is registered. It changes on the first rising clock edge after a change of `led_sel_i` or of the selected source, and not before that edge.
- R3: Select 4'd0 shows the link state. Bit 0 is PLL lock, bit 1 is polling, bit 2 is L0 reached and bit 3 is link up. Bits 7:4 are 0.
- R4: Select 4'd1 copies `user_led_i[7:0]` to `led_o[7:0]` bit for bit.
- R5: Select 4'd2 copies `dip_sw_i[7:0]` to `led_o[7:0]`. An LED is lit when its switch reads 1.
- R6: Select 4'd3 places `flash_sel_i[1:0]` on bits 5:4 and `fpga_sel_i[2:0]` on bits 2:0. Bits 7:6 and bit 3 are 0.
- R7: Selects 4'd4, 4'd5 and 4'd6 show ports 0, 1 and 2. In these views `led_o[7:4]` equals that port's live `port_irq_i` nibble: bit 3 is force interrupt, bit 2 is bus error, bit 1 is request 1 and bit 0 is request 0.
- R8: In a port view, `led_o[3:0]` is a one-hot space record. Bit 3 is memory, bit 2 is INT, bit 1 is IO and bit 0 is ID, using the same bit order as that port's `port_space_stb_i` nibble. The record loads when a strobe rises and is held unchanged after the strobe falls.
- R9: Only the rising edge of a strobe loads the record. A strobe that stays high does not re-load it, so a later rising strobe of another space replaces it.
- R10: When several strobes of one port rise in the same cycle, the record takes the highest-priority one. Memory wins over INT, INT over IO, and IO over ID.
- R11: Select codes 4'd7 through 4'd15 drive `led_o` to 8'h00 whatever the sources hold.
- R12: Each port has its own space record. A strobe on one port leaves the other ports' records unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| led_sel_i | input | 4 | View select |
| pll_lock_i | input | 1 | Serial link PLL locked |
| polling_i | input | 1 | Link training in polling state |
| l0_i | input | 1 | Link has reached L0 |
| link_up_i | input | 1 | Data link layer up |
| user_led_i | input | 8 | Software LED pattern |
| dip_sw_i | input | 8 | DIP switch bank |
| flash_sel_i | input | 2 | Flash image select switches |
| fpga_sel_i | input | 3 | FPGA image select switches |
| port_irq_i | input | 12 | Interrupt status, 4 bits per port; port p uses bits 4p+3:4p |
| port_space_stb_i | input | 12 | Access strobes, 4 per port: {mem, INT, IO, ID} at bits 4p+3:4p |
| led_o | output | 8 | Active-high LED bank |

## Verification
Two events can land in the same cycle, and the bench provokes both. The first is several strobes of one port rising together. The bench raises all four strobes of one port at the same edge, and also IO together with ID. It then checks that the record shows only the winner given by R10. The second is a view change at the same edge as a strobe start on the newly selected port. The bench changes `led_sel_i` and raises the strobe in the same cycle. One edge later it expects the new view to show the freshly loaded space.

// File: rtl/diag_led_pkg.sv
package diag_led_pkg;
    localparam int LED_W      = 8;
    localparam int SEL_W      = 4;
    localparam int NUM_PORTS  = 3;
    localparam int SPACE_N    = 4;
    localparam int IRQ_N      = 4;
    localparam int LINK_N     = 4;
    localparam int FLASH_W    = 2;
    localparam int FPGA_W     = 3;

    // view codes; ports occupy PORT_BASE .. PORT_BASE+NUM_PORTS-1
    localparam int VIEW_LINK   = 0;
    localparam int VIEW_USER   = 1;
    localparam int VIEW_DIP    = 2;
    localparam int VIEW_SWITCH = 3;
    localparam int PORT_BASE   = 4;

    // bit placement in the switch view
    localparam int FLASH_LSB  = 4;
    localparam int FPGA_LSB   = 0;
endpackage

// File: rtl/diag_led_space_trk.sv
module diag_led_space_trk #(
    parameter int SPACES = diag_led_pkg::SPACE_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SPACES-1:0] stb_i,
    output logic [SPACES-1:0] view_o
);
    typedef struct packed {
        logic [SPACES-1:0] prev;
        logic [SPACES-1:0] last;
    } trk_t;

    trk_t              st_d, st_q;
    logic [SPACES-1:0] start;
    logic [SPACES-1:0] pick;

    always_comb begin
        start = stb_i & ~st_q.prev;
        pick  = '0;
        // later (higher) indices overwrite: memory has top priority
        for (int i = 0; i < SPACES; i++) begin
            if (start[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
        st_d.prev = stb_i;
        st_d.last = (|start) ? pick : st_q.last;
        view_o    = st_d.last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_space_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.last));

    assert_top_space_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i[SPACES-1] && !st_q.prev[SPACES-1]) |-> view_o[SPACES-1]);

    // with no strobe rising, the record keeps its value
    assert_record_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((stb_i & ~st_q.prev) == '0) |=> $stable(st_q.last));
endmodule

// File: rtl/diag_led_view_mux.sv
module diag_led_view_mux
    import diag_led_pkg::*;
#(
    parameter int PORTS  = NUM_PORTS,
    parameter int SPACES = SPACE_N,
    parameter int IRQS   = IRQ_N
) (
    input  logic [SEL_W-1:0]        sel_i,
    input  logic [LINK_N-1:0]       link_i,
    input  logic [LED_W-1:0]        user_i,
    input  logic [LED_W-1:0]        dip_i,
    input  logic [FLASH_W-1:0]      flash_i,
    input  logic [FPGA_W-1:0]       fpga_i,
    input  logic [PORTS*IRQS-1:0]   irq_i,
    input  logic [PORTS*SPACES-1:0] space_i,
    output logic [LED_W-1:0]        view_o
);
    localparam int PORT_VIEW_W = IRQS + SPACES;

    always_comb begin
        view_o = '0;
        case (sel_i)
            SEL_W'(VIEW_LINK):   view_o[LINK_N-1:0] = link_i;
            SEL_W'(VIEW_USER):   view_o = user_i;
            SEL_W'(VIEW_DIP):    view_o = dip_i;
            SEL_W'(VIEW_SWITCH): begin
                view_o[FLASH_LSB +: FLASH_W] = flash_i;
                view_o[FPGA_LSB  +: FPGA_W]  = fpga_i;
            end
            default: begin
                for (int p = 0; p < PORTS; p++) begin
                    if (sel_i == SEL_W'(PORT_BASE + p)) begin
                        view_o[PORT_VIEW_W-1:0] = {irq_i[p*IRQS +: IRQS],
                                                   space_i[p*SPACES +: SPACES]};
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/diag_led_mux.sv
module diag_led_mux
    import diag_led_pkg::*;
#(
    parameter int PORTS  = NUM_PORTS,
    parameter int SPACES = SPACE_N,
    parameter int IRQS   = IRQ_N
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SEL_W-1:0]        led_sel_i,
    input  logic                    pll_lock_i,
    input  logic                    polling_i,
    input  logic                    l0_i,
    input  logic                    link_up_i,
    input  logic [LED_W-1:0]        user_led_i,
    input  logic [LED_W-1:0]        dip_sw_i,
    input  logic [FLASH_W-1:0]      flash_sel_i,
    input  logic [FPGA_W-1:0]       fpga_sel_i,
    input  logic [PORTS*IRQS-1:0]   port_irq_i,
    input  logic [PORTS*SPACES-1:0] port_space_stb_i,
    output logic [LED_W-1:0]        led_o
);
    localparam int FIRST_DARK = PORT_BASE + PORTS;

    typedef struct packed {
        logic [LED_W-1:0] led;
    } out_t;

    logic [PORTS*SPACES-1:0] space_view;
    logic [LED_W-1:0]        view;
    out_t                    out_d, out_q;

    for (genvar p = 0; p < PORTS; p++) begin : g_trk
        diag_led_space_trk #(.SPACES(SPACES)) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb_i  (port_space_stb_i[p*SPACES +: SPACES]),
            .view_o (space_view[p*SPACES +: SPACES])
        );

        assert_port_irq_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (led_sel_i == SEL_W'(PORT_BASE + p)) |=>
                (led_o[SPACES +: IRQS] == $past(port_irq_i[p*IRQS +: IRQS])));
    end

    diag_led_view_mux #(.PORTS(PORTS), .SPACES(SPACES), .IRQS(IRQS)) u_mux (
        .sel_i   (led_sel_i),
        .link_i  ({link_up_i, l0_i, polling_i, pll_lock_i}),
        .user_i  (user_led_i),
        .dip_i   (dip_sw_i),
        .flash_i (flash_sel_i),
        .fpga_i  (fpga_sel_i),
        .irq_i   (port_irq_i),
        .space_i (space_view),
        .view_o  (view)
    );

    always_comb begin
        out_d.led = view;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign led_o = out_q.led;

    assert_dark_codes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (led_sel_i >= SEL_W'(FIRST_DARK)) |=> (led_o == '0));

    assert_link_upper_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (led_sel_i == SEL_W'(VIEW_LINK)) |=> (led_o[LED_W-1:LINK_N] == '0));

    assert_user_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (led_sel_i == SEL_W'(VIEW_USER)) |=> (led_o == $past(user_led_i)));

    assert_dip_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (led_sel_i == SEL_W'(VIEW_DIP)) |=> (led_o == $past(dip_sw_i)));

    assert_switch_gaps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (led_sel_i == SEL_W'(VIEW_SWITCH)) |=> (led_o[7:6] == 2'b00 && !led_o[3]));
endmodule

// File: tb/diag_led_mux_tb.sv
`timescale 1ns/1ps
module diag_led_mux_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  led_sel;
    logic        pll_lock, polling, l0, link_up;
    logic [7:0]  user_led, dip_sw;
    logic [1:0]  flash_sel;
    logic [2:0]  fpga_sel;
    logic [11:0] port_irq, port_stb;
    logic [7:0]  led;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    diag_led_mux u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .led_sel_i        (led_sel),
        .pll_lock_i       (pll_lock),
        .polling_i        (polling),
        .l0_i             (l0),
        .link_up_i        (link_up),
        .user_led_i       (user_led),
        .dip_sw_i         (dip_sw),
        .flash_sel_i      (flash_sel),
        .fpga_sel_i       (fpga_sel),
        .port_irq_i       (port_irq),
        .port_space_stb_i (port_stb),
        .led_o            (led)
    );

    typedef struct packed {
        logic [3:0] sel;
        logic [3:0] link;   // {up, l0, polling, pll}
        logic [7:0] user;
        logic [7:0] dip;
        logic [1:0] flash;
        logic [2:0] fpga;
        logic [7:0] exp_led;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  4'b0101, 8'hFF, 8'hFF, 2'b11, 3'b111, 8'h05},
        '{4'd0,  4'b1010, 8'hFF, 8'hFF, 2'b11, 3'b111, 8'h0A},
        '{4'd0,  4'b1111, 8'hFF, 8'hFF, 2'b11, 3'b111, 8'h0F},
        '{4'd1,  4'b1111, 8'hA5, 8'hFF, 2'b11, 3'b111, 8'hA5},
        '{4'd1,  4'b1111, 8'h3C, 8'h00, 2'b11, 3'b111, 8'h3C},
        '{4'd2,  4'b1111, 8'hFF, 8'h96, 2'b11, 3'b111, 8'h96},
        '{4'd2,  4'b1111, 8'h00, 8'h01, 2'b11, 3'b111, 8'h01},
        '{4'd3,  4'b1111, 8'hFF, 8'hFF, 2'b11, 3'b111, 8'h37},
        '{4'd3,  4'b1111, 8'hFF, 8'hFF, 2'b10, 3'b101, 8'h25},
        '{4'd7,  4'b1111, 8'hFF, 8'hFF, 2'b11, 3'b111, 8'h00},
        '{4'd8,  4'b1111, 8'hFF, 8'hFF, 2'b11, 3'b111, 8'h00},
        '{4'd15, 4'b1111, 8'hFF, 8'hFF, 2'b11, 3'b111, 8'h00}
    };

    function automatic string tag_of(logic [3:0] s);
        case (s)
            4'd0:    return "R3";
            4'd1:    return "R4";
            4'd2:    return "R5";
            4'd3:    return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] exp);
        n_cmp++;
        if (led !== exp) begin
            n_bad++;
            $display("FAIL %s: led=%h expected=%h", tag, led, exp);
        end
    endtask

    // inputs are changed at a falling edge; one rising edge later the result is sampled
    task automatic settle;
        @(negedge clk);
    endtask

    initial begin
        led_sel = 4'd0; {link_up, l0, polling, pll_lock} = 4'b1111;
        user_led = 8'hFF; dip_sw = 8'hFF; flash_sel = 2'b11; fpga_sel = 3'b111;
        port_irq = 12'h000; port_stb = 12'h000;
        repeat (3) @(negedge clk);
        check("R1", 8'h00);                         // R1: held in reset
        rst_n = 1'b1;
        led_sel = 4'd4;
        settle();
        check("R1", 8'h00);                         // R1: space records cleared

        port_irq = 12'hFFF;
        for (int i = 0; i < NVEC; i++) begin
            led_sel = VECS[i].sel;
            {link_up, l0, polling, pll_lock} = VECS[i].link;
            user_led = VECS[i].user; dip_sw = VECS[i].dip;
            flash_sel = VECS[i].flash; fpga_sel = VECS[i].fpga;
            settle();
            check(tag_of(VECS[i].sel), VECS[i].exp_led);
        end
        port_irq = 12'h000;

        // R2: output changes only at the clock edge
        led_sel = 4'd1; user_led = 8'h5A;
        settle();
        led_sel = 4'd2; dip_sw = 8'hC3;
        #1 check("R2", 8'h5A);
        settle();
        check("R2", 8'hC3);

        // R7: live interrupt bits per port
        port_irq = 12'h6_3_9;                       // port2=0110 port1=0011 port0=1001
        led_sel = 4'd4; settle(); check("R7", 8'h90);
        led_sel = 4'd5; settle(); check("R7", 8'h30);
        led_sel = 4'd6; settle(); check("R7", 8'h60);
        port_irq = 12'h000;

        // R8: IO strobe on port0 loads and then holds
        led_sel = 4'd4; port_stb[1] = 1'b1;
        settle(); check("R8", 8'h02);
        port_stb[1] = 1'b0;
        repeat (3) settle();
        check("R8", 8'h02);

        // R9: INT held high, ID rises later and wins, nothing re-loads while held
        port_stb[2] = 1'b1;
        settle(); check("R9", 8'h04);
        port_stb[0] = 1'b1;
        settle(); check("R9", 8'h01);
        repeat (3) settle();
        check("R9", 8'h01);
        port_stb[3:0] = 4'b0000;
        settle();

        // R10: all four of port1 rise together -> memory; then IO+ID -> IO on port2
        led_sel = 4'd5; port_stb[7:4] = 4'b1111;
        settle(); check("R10", 8'h08);
        port_stb[7:4] = 4'b0000;
        led_sel = 4'd6; port_stb[9:8] = 2'b11;      // same-cycle view change + start
        settle(); check("R10", 8'h02);
        port_stb[9:8] = 2'b00;
        port_stb[10] = 1'b1;                        // INT+IO on port2 -> INT
        port_stb[9]  = 1'b1;
        settle(); check("R10", 8'h04);
        port_stb[10:9] = 2'b00;
        settle();

        // R12: port2 memory strobe leaves ports 0 and 1 untouched
        port_stb[11] = 1'b1;
        settle(); check("R12", 8'h08);
        port_stb[11] = 1'b0;
        led_sel = 4'd4; settle(); check("R12", 8'h01);
        led_sel = 4'd5; settle(); check("R12", 8'h08);

        // R11: port-like data present, dark code still blank
        port_irq = 12'hFFF; led_sel = 4'd9;
        settle(); check("R11", 8'h00);

        // R1: reset mid-run clears output and records
        rst_n = 1'b0; led_sel = 4'd4; port_irq = 12'h000;
        settle(); check("R1", 8'h00);
        rst_n = 1'b1;
        settle(); check("R1", 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: led=%h expected=finished run", led);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule